// File: doc/BRIEF.md
# Vector Condition-Register Predicate-Result Writer

This block runs the write-back stage of a vectorised condition-register operation when predicate-result mode is selected. A start pulse captures a job description. The job gives the vector length, a destination predicate mask, the zeroing flag, the non-zero fill value (SNZ), the invert flag, a result-bit selector and an operand-width flag. The width flag picks between whole 4-bit fields and single bits. It also gives a base field or bit number and the starting 32-bit condition register contents. The block then walks the elements, one per clock, and presents each element index. The datapath returns that element's operation result in the same cycle. For each element the block decides whether to write, what to write and where.

An element whose predicate bit is set is tested. In bit mode the tested value is the single result bit. In field mode the selector picks one of the four result bits. The write goes ahead only when the tested bit equals the invert flag. The test outcome is in effect ANDed with the destination predicate. An element whose predicate bit is clear is skipped when zeroing is off. When zeroing is on, the SNZ value is written untested, filled to the operand width. The block holds the condition register, updates it with each write, and shows it on `cr_q`.

Top module: `cr_predres_writer`

## Requirements
- R1: After reset `busy`, `done` and `wr_en` are 0 and `cr_q` is all zeros.
- R2: A `start` seen while idle captures every `cfg_*` input and loads `cr_init` into `cr_q` at that edge. A `start` seen while busy has no effect on the running job.
- R3: The elements are visited in ascending order from 0 to VL-1, one per clock. `elem_idx` gives the current element while `busy` is 1. `busy` stays 1 for exactly VL cycles and is followed by a one-cycle `done` pulse.
- R4: A job with VL = 0 writes nothing, never raises `busy`, and raises `done` in the cycle after `start`.
- R5: An element whose mask bit is 0 while `cfg_zero` = 0 produces no write.
- R6: In bit mode (`cfg_bitmode` = 1), an element whose mask bit is 0 while `cfg_zero` = 1 is written untested, with `wr_data` = {3'b000, SNZ}.
- R7: In field mode (`cfg_bitmode` = 0), an element whose mask bit is 0 while `cfg_zero` = 1 is written untested, with `wr_data` equal to four copies of SNZ.
- R8: In bit mode, an active element tests `elem_res[0]`. It is written with `wr_data` = {3'b000, elem_res[0]} only when that bit equals `cfg_inv`.
- R9: In field mode, an active element tests `elem_res[cfg_sel]`. It is written with `wr_data` = `elem_res` only when that bit equals `cfg_inv`.
- R10: The target of element i is (`cfg_base` + i) mod 32 in bit mode. In field mode it is (`cfg_base[2:0]` + i) mod 8. Field f occupies `cr_q[4f+3:4f]`, and result bit k lands on `cr_q[4f+k]`.
- R11: A write changes only its target bit (bit mode) or its target 4-bit field (field mode), and it takes effect on `cr_q` at the next clock edge. Without a write, `cr_q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (taken only while idle) |
| cfg_vl | input | $clog2(MAXVL+1) | Vector length |
| cfg_bitmode | input | 1 | 1: single-bit operands, 0: 4-bit field operands |
| cfg_zero | input | 1 | Zeroing flag for masked-out elements |
| cfg_snz | input | 1 | Fill value for masked-out elements under zeroing |
| cfg_inv | input | 1 | Value the tested bit must equal for a write |
| cfg_sel | input | 2 | Result bit tested in field mode |
| cfg_base | input | 5 | Base bit number (bit mode) or base field in bits 2:0 |
| cfg_mask | input | MAXVL | Destination predicate, bit i for element i |
| cr_init | input | 32 | Condition register contents loaded at start |
| elem_res | input | 4 | Operation result of element `elem_idx` |
| elem_idx | output | $clog2(MAXVL) | Element being processed |
| busy | output | 1 | A job is being walked |
| done | output | 1 | One-cycle pulse when a job ends |
| wr_en | output | 1 | This element's result is written this cycle |
| wr_tgt | output | 5 | Bit number or field number written |
| wr_data | output | 4 | Value written (bit 0 only in bit mode) |
| cr_q | output | 32 | Current condition register contents |

## Verification
The hardest case to reach is a start pulse that arrives while a job is running, with a conflicting description: a zero length, a different base and the other width. A correct design discards it, so its only trace is a run that continues untouched. The stimulus raises `start` with such a description in the second element cycle of a field-mode job. The bench then checks every remaining write and the final register against the original job. Wrap-around of targets at bit 31 and field 7 is reached through base values near the top, with vector lengths that cross the boundary.

// File: rtl/crpr_pkg.sv
package crpr_pkg;

  localparam int CR_W    = 32;
  localparam int FIELD_W = 4;
  localparam int TGT_W   = 5;

  // bit picked for the condition test
  function automatic logic probe_bit(input logic [FIELD_W-1:0] res,
                                     input logic bitmode,
                                     input logic [1:0] sel);
    return bitmode ? res[0] : res[sel];
  endfunction

  // untested fill for a masked-out element under zeroing
  function automatic logic [FIELD_W-1:0] fill_value(input logic snz,
                                                    input logic bitmode);
    return bitmode ? {3'b000, snz} : {FIELD_W{snz}};
  endfunction

  // destination index with wrap at the register size
  function automatic logic [TGT_W-1:0] dest_index(input logic [TGT_W-1:0] base,
                                                  input logic [TGT_W-1:0] off,
                                                  input logic bitmode);
    logic [2:0] fld;
    fld = base[2:0] + off[2:0];
    return bitmode ? TGT_W'(base + off) : {2'b00, fld};
  endfunction

endpackage

// File: rtl/crpr_seq.sv
module crpr_seq #(
  parameter int MAXVL = 16,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  output logic            load,
  output logic            busy,
  output logic            done,
  output logic [IDXW-1:0] idx
);

  logic [VLW-1:0] vl_q;
  logic           last_elem;

  assign load      = start && !busy;
  assign last_elem = (VLW'(idx) + VLW'(1)) == vl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      idx  <= '0;
      vl_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        idx  <= '0;
        vl_q <= vl;
        busy <= (vl != '0);
        done <= (vl == '0);
      end else if (busy) begin
        if (last_elem) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + IDXW'(1);
        end
      end
    end
  end

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_elem) |=> (busy && idx == IDXW'($past(idx) + IDXW'(1))));

  assert_end_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_elem) |=> (done && !busy));

  assert_vl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && vl == '0) |=> (done && !busy));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: rtl/crpr_decide.sv
module crpr_decide
  import crpr_pkg::*;
(
  input  logic               valid,
  input  logic               active,
  input  logic               zero,
  input  logic               snz,
  input  logic               inv,
  input  logic               bitmode,
  input  logic [1:0]         sel,
  input  logic [TGT_W-1:0]   base,
  input  logic [TGT_W-1:0]   off,
  input  logic [FIELD_W-1:0] res,
  output logic               we,
  output logic [FIELD_W-1:0] data,
  output logic [TGT_W-1:0]   tgt
);

  logic test_pass;

  assign test_pass = (probe_bit(res, bitmode, sel) == inv);
  assign tgt       = dest_index(base, off, bitmode);

  always_comb begin
    we   = 1'b0;
    data = '0;
    if (valid) begin
      if (!active) begin
        we   = zero;
        data = zero ? fill_value(snz, bitmode) : '0;
      end else begin
        we   = test_pass;
        data = bitmode ? {3'b000, res[0]} : res;
      end
    end
  end

endmodule

// File: rtl/crpr_crfile.sv
module crpr_crfile
  import crpr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [CR_W-1:0]    init,
  input  logic               we,
  input  logic               bitmode,
  input  logic [TGT_W-1:0]   tgt,
  input  logic [FIELD_W-1:0] data,
  output logic [CR_W-1:0]    cr_q
);

  for (genvar b = 0; b < CR_W; b++) begin : g_bit
    logic hit;
    logic val;
    assign hit = we && (bitmode ? (tgt == TGT_W'(b)) : (tgt[2:0] == 3'(b / FIELD_W)));
    assign val = bitmode ? data[0] : data[b % FIELD_W];
    always_ff @(posedge clk) begin
      if (!rst_n)   cr_q[b] <= 1'b0;
      else if (load) cr_q[b] <= init[b];
      else if (hit)  cr_q[b] <= val;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !load) |=> $stable(cr_q));

  assert_one_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bitmode && !load) |=> ($countones(cr_q ^ $past(cr_q)) <= 1));

  assert_bit_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bitmode && !load) |=> (cr_q[$past(tgt)] == $past(data[0])));

  assert_field_span_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !bitmode && !load) |=> ($countones(cr_q ^ $past(cr_q)) <= FIELD_W));

endmodule

// File: rtl/cr_predres_writer.sv
module cr_predres_writer
  import crpr_pkg::*;
#(
  parameter int MAXVL = 16,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IDXW = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VLW-1:0]     cfg_vl,
  input  logic               cfg_bitmode,
  input  logic               cfg_zero,
  input  logic               cfg_snz,
  input  logic               cfg_inv,
  input  logic [1:0]         cfg_sel,
  input  logic [TGT_W-1:0]   cfg_base,
  input  logic [MAXVL-1:0]   cfg_mask,
  input  logic [CR_W-1:0]    cr_init,
  input  logic [FIELD_W-1:0] elem_res,
  output logic [IDXW-1:0]    elem_idx,
  output logic               busy,
  output logic               done,
  output logic               wr_en,
  output logic [TGT_W-1:0]   wr_tgt,
  output logic [FIELD_W-1:0] wr_data,
  output logic [CR_W-1:0]    cr_q
);

  logic               load;
  logic               bm_q, zero_q, snz_q, inv_q;
  logic [1:0]         sel_q;
  logic [TGT_W-1:0]   base_q;
  logic [MAXVL-1:0]   mask_q;
  logic               elem_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bm_q   <= 1'b0;
      zero_q <= 1'b0;
      snz_q  <= 1'b0;
      inv_q  <= 1'b0;
      sel_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (load) begin
      bm_q   <= cfg_bitmode;
      zero_q <= cfg_zero;
      snz_q  <= cfg_snz;
      inv_q  <= cfg_inv;
      sel_q  <= cfg_sel;
      base_q <= cfg_base;
      mask_q <= cfg_mask;
    end
  end

  assign elem_active = mask_q[elem_idx];

  crpr_seq #(.MAXVL(MAXVL)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vl    (cfg_vl),
    .load  (load),
    .busy  (busy),
    .done  (done),
    .idx   (elem_idx)
  );

  crpr_decide u_decide (
    .valid   (busy),
    .active  (elem_active),
    .zero    (zero_q),
    .snz     (snz_q),
    .inv     (inv_q),
    .bitmode (bm_q),
    .sel     (sel_q),
    .base    (base_q),
    .off     (TGT_W'(elem_idx)),
    .res     (elem_res),
    .we      (wr_en),
    .data    (wr_data),
    .tgt     (wr_tgt)
  );

  crpr_crfile u_crfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .init    (cr_init),
    .we      (wr_en),
    .bitmode (bm_q),
    .tgt     (wr_tgt),
    .data    (wr_data),
    .cr_q    (cr_q)
  );

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_en);

  assert_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_active && !zero_q) |-> !wr_en);

  assert_bit_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_active && zero_q && bm_q) |-> (wr_en && wr_data == {3'b000, snz_q}));

  assert_field_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !elem_active && zero_q && !bm_q) |-> (wr_en && $countones(wr_data) == (snz_q ? 4 : 0)));

  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(bm_q) && $stable(base_q) && $stable(mask_q)));

endmodule

// File: tb/test_cr_predres_writer.sv
module test_cr_predres_writer;

  localparam int MAXVL = 16;
  localparam int VLW   = $clog2(MAXVL + 1);
  localparam int IDXW  = $clog2(MAXVL);

  typedef struct packed {
    logic [4:0]  vl;
    logic        bm;
    logic        zero;
    logic        snz;
    logic        inv;
    logic [1:0]  sel;
    logic [4:0]  base;
    logic [15:0] mask;
    logic [31:0] init;
    logic [3:0]  seed;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{5'd8,  1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 5'd0,  16'hFFFF, 32'h0000_0000, 4'd3},
    '{5'd6,  1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 5'd2,  16'h002D, 32'h0F0F_0F0F, 4'd9},
    '{5'd4,  1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 5'd6,  16'h0005, 32'hFFFF_FFFF, 4'd5},
    '{5'd10, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 5'd3,  16'h03F3, 32'h0000_0000, 4'd6},
    '{5'd8,  1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 5'd28, 16'h00A5, 32'h1234_5678, 4'd12},
    '{5'd16, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 5'd0,  16'hF0F0, 32'hFFFF_FFFF, 4'd1},
    '{5'd5,  1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 5'd4,  16'h0000, 32'hDEAD_BEEF, 4'd7},
    '{5'd8,  1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 5'd0,  16'h0000, 32'h0000_0000, 4'd2},
    '{5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 5'd1,  16'hFFFF, 32'hA5A5_5A5A, 4'd10},
    '{5'd1,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 5'd31, 16'h0001, 32'h8000_0000, 4'd0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [VLW-1:0]   cfg_vl = '0;
  logic             cfg_bitmode = 1'b0, cfg_zero = 1'b0, cfg_snz = 1'b0, cfg_inv = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [4:0]       cfg_base = '0;
  logic [MAXVL-1:0] cfg_mask = '0;
  logic [31:0]      cr_init = '0;
  logic [3:0]       elem_res;
  logic [IDXW-1:0]  elem_idx;
  logic             busy, done, wr_en;
  logic [4:0]       wr_tgt;
  logic [3:0]       wr_data;
  logic [31:0]      cr_q;
  logic [3:0]       cur_seed = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [3:0] res_of(input logic [3:0] seed, input int i);
    return 4'((int'(seed) * 5 + i * 7 + (i >> 1)) & 15);
  endfunction

  assign elem_res = res_of(cur_seed, int'(elem_idx));

  cr_predres_writer #(.MAXVL(MAXVL)) i_cr_predres_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_vl(cfg_vl),
    .cfg_bitmode(cfg_bitmode), .cfg_zero(cfg_zero), .cfg_snz(cfg_snz),
    .cfg_inv(cfg_inv), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_mask(cfg_mask), .cr_init(cr_init), .elem_res(elem_res),
    .elem_idx(elem_idx), .busy(busy), .done(done), .wr_en(wr_en),
    .wr_tgt(wr_tgt), .wr_data(wr_data), .cr_q(cr_q)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_cfg(input vec_t v);
    cfg_vl      = VLW'(v.vl);
    cfg_bitmode = v.bm;
    cfg_zero    = v.zero;
    cfg_snz     = v.snz;
    cfg_inv     = v.inv;
    cfg_sel     = v.sel;
    cfg_base    = v.base;
    cfg_mask    = v.mask;
    cr_init     = v.init;
  endtask

  // runs one job; poke=1 raises a conflicting start during element 1
  task automatic run_vec(input vec_t v, input logic poke);
    logic [31:0] model;
    model = v.init;
    @(negedge clk);
    drive_cfg(v);
    cur_seed = v.seed;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cr_q == v.init, "R2 load", cr_q, v.init);
    for (int k = 0; k < int'(v.vl); k++) begin
      logic [3:0] r, ed;
      logic       on, ew, tb;
      logic [4:0] et;
      r  = res_of(v.seed, k);
      on = v.mask[k];
      ew = 1'b0;
      ed = 4'h0;
      if (!on) begin
        if (v.zero) begin
          ew = 1'b1;
          ed = v.snz ? (v.bm ? 4'h1 : 4'hF) : 4'h0;
        end
      end else begin
        tb = v.bm ? r[0] : ((r >> v.sel) & 4'h1) != 0;
        if (tb == v.inv) begin
          ew = 1'b1;
          ed = v.bm ? {3'b000, r[0]} : r;
        end
      end
      et = v.bm ? 5'((int'(v.base) + k) % 32) : 5'((int'(v.base % 8) + k) % 8);
      chk(busy && int'(elem_idx) == k, "R3 order", 32'(elem_idx), 32'(k));
      chk(wr_en == ew, on ? (v.bm ? "R8 write" : "R9 write")
                          : (v.zero ? (v.bm ? "R6 fill" : "R7 fill") : "R5 skip"),
          32'(wr_en), 32'(ew));
      if (ew) begin
        chk(wr_data == ed, v.bm ? "R8 data" : "R9 data", 32'(wr_data), 32'(ed));
        chk(wr_tgt == et, "R10 target", 32'(wr_tgt), 32'(et));
        if (v.bm) model[et] = ed[0];
        else for (int b = 0; b < 4; b++) model[int'(et) * 4 + b] = ed[b];
      end
      if (poke && k == 1) begin
        cfg_vl = '0; cfg_base = 5'd17; cfg_bitmode = ~v.bm; cfg_mask = '0;
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk(cr_q == model, "R11 update", cr_q, model);
    end
    chk(done && !busy, "R3 done", {busy, done}, 32'b01);
    chk(cr_q == model, "R11 final", cr_q, model);
    @(negedge clk);
    chk(!done, "R3 pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !wr_en, "R1 ctrl", {busy, done, wr_en}, 32'd0);
    chk(cr_q == 32'd0, "R1 cr", cr_q, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wr_en, "R1 idle", {busy, wr_en}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R4: zero-length job
    v = VECS[0];
    v.vl = 5'd0;
    v.init = 32'hCAFE_F00D;
    @(negedge clk);
    drive_cfg(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy && !wr_en, "R4 done", {busy, done, wr_en}, 32'b010);
    chk(cr_q == 32'hCAFE_F00D, "R4 cr", cr_q, 32'hCAFE_F00D);
    @(negedge clk);
    chk(!done && cr_q == 32'hCAFE_F00D, "R4 quiet", cr_q, 32'hCAFE_F00D);

    // R2: start while busy is ignored
    run_vec(VECS[1], 1'b1);
    run_vec(VECS[4], 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule